// File: doc/BRIEF.md
# Exponentiation Result Cache

This block sits beside a bank of parallel modular-exponentiation engines and remembers which input blocks have already been processed under the current key. Before a block taken from the read buffer is sent to an engine, it is presented on the lookup port. One cycle later the block reports whether that exact value was seen before and, if so, drives the stored processed block so that the slow computation can be skipped.

The cache is fully associative and is indexed by the data value itself: the tag is the complete input block. Several fill ports, one for each compute engine, deliver finished (input, result) pairs, and all of them may be active in the same cycle. New keys take entries in a round-robin order. A key that is already held is rewritten in place. A flush input empties the cache and must be pulsed whenever the exponent or the modulus changes, because every stored result depends on both.

Top module: `rsa_result_cache`

## Requirements
- R1: While reset is high, and in the cycle after it, `lk_hit` is 0 and `lk_res` is 0. Reset leaves no entry valid and sets the replacement pointer to entry 0.
- R2: A lookup presented with `lk_vld` high in cycle t is answered on `lk_hit` and `lk_res` in cycle t+1. If `lk_vld` is low in cycle t, `lk_hit` is 0 in cycle t+1, even when the key is stored.
- R3: On a miss, `lk_hit` is 0 and `lk_res` is all zeros.
- R4: A pair accepted on any fill port in cycle t is visible to lookups from cycle t+1. Such a lookup returns `lk_hit` = 1 and the filled result.
- R5: A lookup whose key is filled in the same cycle, and was not stored before, reports a miss. The same key hits on the following lookup.
- R6: A fill whose key is already stored overwrites that entry's result. It does not take a new entry and does not move the replacement pointer.
- R7: Each new key is written at the replacement pointer, which then advances by one modulo DEPTH. Once all entries are full, the entry allocated earliest is the one evicted.
- R8: When several fill ports carry distinct new keys in one cycle, each key gets its own entry. Port 0 takes the pointer position, and each higher port takes the next position in port order.
- R9: When two fill ports carry the same key in one cycle, one entry is used and the result on the higher-numbered port is kept.
- R10: In the edge after `flush` is high, all entries become invalid and the pointer returns to entry 0. A lookup in the flush cycle reports a miss, and fills in the flush cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries (key change) |
| lk_vld | input | 1 | Lookup request valid |
| lk_key | input | KEY_W | Input block to look up |
| fill_vld | input | NFILL | Per-port fill valid |
| fill_key | input | NFILL x KEY_W | Per-port input block of the finished pair |
| fill_res | input | NFILL x RES_W | Per-port processed block of the finished pair |
| lk_hit | output | 1 | Registered hit flag for the previous cycle's lookup |
| lk_res | output | RES_W | Stored result on a hit, zero on a miss |

## Verification
A corrupted tag, valid bit or result shows at the ports on the next lookup of the affected key, one cycle after that lookup is presented. A replacement pointer that has drifted stays hidden until all entries are full. After that, the next allocation evicts the wrong key, and this appears as an unexpected hit on a key that should have been evicted or a miss on a key that should still be held. The stimulus therefore fills the cache past capacity, both before and after a flush, and then probes both the evicted key and the key that should survive. It also covers in-place updates and same-key fills on two ports, where a second allocation would displace an extra key.

// File: rtl/rsa_cache_pkg.sv
package rsa_cache_pkg;

    // Default geometry of the cache
    localparam int unsigned DEF_KEY_W = 16;
    localparam int unsigned DEF_RES_W = 16;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_NFILL = 2;

    // Position a given number of steps after base on a ring of depth entries
    function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                             int unsigned depth);
        return (base + step) % depth;
    endfunction

endpackage

// File: rtl/cache_match.sv
module cache_match #(
    parameter int unsigned KEY_W = 16,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [KEY_W-1:0]            key,
    input  logic [DEPTH-1:0][KEY_W-1:0] tags,
    input  logic [DEPTH-1:0]            valid,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    // Full-value tag compare across every entry
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (valid[i] && tags[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cache_alloc.sv
module cache_alloc
    import rsa_cache_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NFILL = 2,
    parameter int unsigned IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic [NFILL-1:0]            need,
    output logic [NFILL-1:0][IDX_W-1:0] slot
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_d;

    // Ports that need a new entry take consecutive ring positions in port order
    always_comb begin
        int unsigned cnt;
        cnt = 0;
        for (int j = 0; j < int'(NFILL); j++) begin
            slot[j] = IDX_W'(ring_add(int'(ptr_q), cnt, DEPTH));
            if (need[j]) cnt = cnt + 1;
        end
        ptr_d = IDX_W'(ring_add(int'(ptr_q), cnt, DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) ptr_q <= '0;
        else              ptr_q <= ptr_d;
    end
endmodule

// File: rtl/cache_store.sv
module cache_store #(
    parameter int unsigned KEY_W = 16,
    parameter int unsigned RES_W = 16,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NFILL = 2,
    parameter int unsigned IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic [NFILL-1:0]            wr_en,
    input  logic [NFILL-1:0][IDX_W-1:0] wr_idx,
    input  logic [NFILL-1:0][KEY_W-1:0] wr_key,
    input  logic [NFILL-1:0][RES_W-1:0] wr_res,
    output logic [DEPTH-1:0][KEY_W-1:0] tags,
    output logic [DEPTH-1:0][RES_W-1:0] ress,
    output logic [DEPTH-1:0]            valid
);
    typedef struct packed {
        logic [KEY_W-1:0] tag;
        logic [RES_W-1:0] res;
    } entry_t;

    entry_t [DEPTH-1:0] mem;

    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_out
        assign tags[i] = mem[i].tag;
        assign ress[i] = mem[i].res;
    end

    // Whole-entry writes in port order: a higher port wins on a shared index
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= '0;
        end else begin
            for (int j = 0; j < int'(NFILL); j++) begin
                if (wr_en[j]) begin
                    mem[wr_idx[j]]   <= '{tag: wr_key[j], res: wr_res[j]};
                    valid[wr_idx[j]] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsa_result_cache.sv
module rsa_result_cache
    import rsa_cache_pkg::*;
#(
    parameter int unsigned KEY_W = DEF_KEY_W,
    parameter int unsigned RES_W = DEF_RES_W,
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned NFILL = DEF_NFILL
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        lk_vld,
    input  logic [KEY_W-1:0]            lk_key,
    input  logic [NFILL-1:0]            fill_vld,
    input  logic [NFILL-1:0][KEY_W-1:0] fill_key,
    input  logic [NFILL-1:0][RES_W-1:0] fill_res,
    output logic                        lk_hit,
    output logic [RES_W-1:0]            lk_res
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][KEY_W-1:0] st_tags;
    logic [DEPTH-1:0][RES_W-1:0] st_ress;
    logic [DEPTH-1:0]            st_valid;

    logic [NFILL-1:0]            f_hit;
    logic [NFILL-1:0][IDX_W-1:0] f_idx;
    logic [NFILL-1:0]            later_same;
    logic [NFILL-1:0]            fill_go;
    logic [NFILL-1:0]            need;
    logic [NFILL-1:0][IDX_W-1:0] slot;
    logic [NFILL-1:0][IDX_W-1:0] wr_idx;

    logic             l_hit;
    logic [IDX_W-1:0] l_idx;

    // Lookup compare against the state held before this edge
    cache_match #(.KEY_W(KEY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_lk_match (
        .key(lk_key), .tags(st_tags), .valid(st_valid), .hit(l_hit), .idx(l_idx)
    );

    for (genvar j = 0; j < int'(NFILL); j++) begin : g_fill
        cache_match #(.KEY_W(KEY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_f_match (
            .key(fill_key[j]), .tags(st_tags), .valid(st_valid),
            .hit(f_hit[j]), .idx(f_idx[j])
        );
        assign wr_idx[j] = f_hit[j] ? f_idx[j] : slot[j];
    end

    // A port yields to any higher port carrying the same key this cycle
    always_comb begin
        later_same = '0;
        for (int j = 0; j < int'(NFILL); j++) begin
            for (int k = j + 1; k < int'(NFILL); k++) begin
                if (fill_vld[k] && fill_key[k] == fill_key[j]) later_same[j] = 1'b1;
            end
        end
    end

    assign fill_go = fill_vld & ~later_same & {NFILL{~flush}};
    assign need    = fill_go & ~f_hit;

    cache_alloc #(.DEPTH(DEPTH), .NFILL(NFILL), .IDX_W(IDX_W)) u_alloc (
        .clk(clk), .rst(rst), .flush(flush), .need(need), .slot(slot)
    );

    cache_store #(.KEY_W(KEY_W), .RES_W(RES_W), .DEPTH(DEPTH), .NFILL(NFILL),
                  .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(fill_go), .wr_idx(wr_idx), .wr_key(fill_key), .wr_res(fill_res),
        .tags(st_tags), .ress(st_ress), .valid(st_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit <= 1'b0;
            lk_res <= '0;
        end else begin
            lk_hit <= lk_vld && l_hit && !flush;
            lk_res <= (lk_vld && l_hit && !flush) ? st_ress[l_idx] : '0;
        end
    end
endmodule

// File: rtl/rsa_result_cache_chk.sv
module rsa_result_cache_chk #(
    parameter int unsigned KEY_W = 16,
    parameter int unsigned RES_W = 16,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NFILL = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        flush,
    input logic                        lk_vld,
    input logic [KEY_W-1:0]            lk_key,
    input logic [NFILL-1:0]            fill_vld,
    input logic [NFILL-1:0][KEY_W-1:0] fill_key,
    input logic [NFILL-1:0][RES_W-1:0] fill_res,
    input logic                        lk_hit,
    input logic [RES_W-1:0]            lk_res,
    input logic [DEPTH-1:0][KEY_W-1:0] tags,
    input logic [DEPTH-1:0]            valid
);
    // Track the top fill port (never overridden) into a following lookup
    logic             s1_v, s2_v;
    logic [KEY_W-1:0] s1_k;
    logic [RES_W-1:0] s1_r, s2_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s1_k <= '0;
            s1_r <= '0;
            s2_r <= '0;
        end else begin
            s1_v <= fill_vld[NFILL-1] && !flush;
            s1_k <= fill_key[NFILL-1];
            s1_r <= fill_res[NFILL-1];
            s2_v <= s1_v && lk_vld && lk_key == s1_k && !flush;
            s2_r <= s1_r;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!lk_hit && lk_res == '0));

    p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> $past(lk_vld));

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_res == '0);

    p_fill_visible_r4: assert property (@(posedge clk) disable iff (rst)
        s2_v |-> (lk_hit && lk_res == s2_r));

    p_flush_miss_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R6 / R9: no key is ever held by two valid entries
    always @(posedge clk) begin
        if (!rst) begin
            for (int a = 0; a < int'(DEPTH); a++) begin
                for (int b = a + 1; b < int'(DEPTH); b++) begin
                    p_unique_tag_r6: assert (!(valid[a] && valid[b] && tags[a] == tags[b]));
                end
            end
        end
    end
endmodule

bind rsa_result_cache rsa_result_cache_chk #(
    .KEY_W(KEY_W), .RES_W(RES_W), .DEPTH(DEPTH), .NFILL(NFILL)
) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .lk_vld(lk_vld), .lk_key(lk_key),
    .fill_vld(fill_vld), .fill_key(fill_key), .fill_res(fill_res),
    .lk_hit(lk_hit), .lk_res(lk_res), .tags(st_tags), .valid(st_valid)
);

// File: tb/rsa_result_cache_bench.sv
module rsa_result_cache_bench;
    localparam int KW = 16;
    localparam int RW = 16;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 flush;
    logic                 lk_vld;
    logic [KW-1:0]        lk_key;
    logic [1:0]           fill_vld;
    logic [1:0][KW-1:0]   fill_key;
    logic [1:0][RW-1:0]   fill_res;
    logic                 lk_hit;
    logic [RW-1:0]        lk_res;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rsa_result_cache #(.KEY_W(KW), .RES_W(RW), .DEPTH(8), .NFILL(2)) u_rsa_result_cache (
        .clk(clk), .rst(rst), .flush(flush), .lk_vld(lk_vld), .lk_key(lk_key),
        .fill_vld(fill_vld), .fill_key(fill_key), .fill_res(fill_res),
        .lk_hit(lk_hit), .lk_res(lk_res)
    );

    typedef struct packed {
        logic          lv;
        logic [KW-1:0] lk;
        logic          v0;
        logic [KW-1:0] k0;
        logic [RW-1:0] r0;
        logic          v1;
        logic [KW-1:0] k1;
        logic [RW-1:0] r1;
        logic          fl;
        logic          eh;
        logic [RW-1:0] er;
    } vec_t;

    // One row per cycle: lookup, port0 fill, port1 fill, flush, expected answer
    localparam vec_t TBL [10] = '{
        '{1'b1, 16'h0011, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R3
        '{1'b1, 16'h0011, 1'b1, 16'h0011, 16'hA011, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R5
        '{1'b1, 16'h0011, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'hA011}, // R5
        '{1'b1, 16'h0022, 1'b1, 16'h0033, 16'hA033, 1'b1, 16'h0022, 16'hB022, 1'b0, 1'b0, 16'h0000}, // R8
        '{1'b1, 16'h0022, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'hB022}, // R4
        '{1'b1, 16'h0033, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'hA033}, // R8
        '{1'b1, 16'h0044, 1'b1, 16'h0011, 16'hC011, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R3
        '{1'b1, 16'h0011, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'hC011}, // R6
        '{1'b0, 16'h0011, 1'b1, 16'h0055, 16'h5555, 1'b1, 16'h0055, 16'h6666, 1'b0, 1'b0, 16'h0000}, // R2
        '{1'b1, 16'h0055, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h6666}  // R9
    };

    task automatic check(input string req, input logic eh, input logic [RW-1:0] er);
        total++;
        if (lk_hit !== eh || lk_res !== er) begin
            bad++;
            $display("FAIL %s: hit=%0b res=%h expected hit=%0b res=%h", req, lk_hit, lk_res, eh, er);
        end
    endtask

    // Drive one cycle at a falling edge, return at the next falling edge
    task automatic cyc(input vec_t v);
        lk_vld      = v.lv;
        lk_key      = v.lk;
        fill_vld[0] = v.v0;
        fill_key[0] = v.k0;
        fill_res[0] = v.r0;
        fill_vld[1] = v.v1;
        fill_key[1] = v.k1;
        fill_res[1] = v.r1;
        flush       = v.fl;
        @(negedge clk);
    endtask

    task automatic fill(input logic [KW-1:0] k, input logic [RW-1:0] r);
        cyc('{1'b0, 16'h0, 1'b1, k, r, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 16'h0});
    endtask

    task automatic look(input logic [KW-1:0] k, input logic eh, input logic [RW-1:0] er,
                        input string req);
        cyc('{1'b1, k, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 16'h0});
        check(req, eh, er);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        flush = 1'b0;
        lk_vld = 1'b0;
        lk_key = '0;
        fill_vld = '0;
        fill_key = '0;
        fill_res = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset", 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, '0);

        for (int i = 0; i < 10; i++) begin
            cyc(TBL[i]);
            check($sformatf("table row %0d", i), TBL[i].eh, TBL[i].er);
        end

        // Entries: 0=0011 1=0033 2=0022 3=0055, pointer at 4. Fill to capacity.
        for (int i = 0; i < 4; i++) fill(16'h0100 + 16'(i), 16'h1100 + 16'(i));
        fill(16'h0200, 16'h2200);                        // R7: wraps to entry 0
        look(16'h0011, 1'b0, 16'h0000, "R7 oldest evicted");
        look(16'h0033, 1'b1, 16'hA033, "R9 one entry for shared key");
        look(16'h0200, 1'b1, 16'h2200, "R7 new key stored");

        fill(16'h0022, 16'hD022);                        // R6: update, pointer stays at 1
        fill(16'h0201, 16'h2201);                        // evicts entry 1 (0033)
        look(16'h0022, 1'b1, 16'hD022, "R6 in-place update");
        look(16'h0033, 1'b0, 16'h0000, "R7 next oldest evicted");
        look(16'h0055, 1'b1, 16'h6666, "R6 update took no entry");
        look(16'h0103, 1'b1, 16'h1103, "R4 older fill retained");

        // R10: flush with a concurrent lookup and fill
        cyc('{1'b1, 16'h0022, 1'b1, 16'h0300, 16'h3300, 1'b0, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0});
        check("R10 lookup during flush", 1'b0, '0);
        look(16'h0022, 1'b0, 16'h0000, "R10 entry cleared");
        look(16'h0300, 1'b0, 16'h0000, "R10 fill in flush cycle dropped");

        for (int i = 0; i < 8; i++) fill(16'h0400 + 16'(i), 16'h4400 + 16'(i));
        fill(16'h0500, 16'h5500);
        look(16'h0400, 1'b0, 16'h0000, "R10 pointer restarted at entry 0");
        look(16'h0401, 1'b1, 16'h4401, "R10 entry 1 retained");
        look(16'h0500, 1'b1, 16'h5500, "R4 fill after flush");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule